// File: doc/BRIEF.md
# Switch Request Gating Unit

This block sits between the regulation loop's raw cycle request and the driver that sends the request across the isolation barrier. Each clock cycle it decides whether the raw request may go through. A request is held back if passing it would exceed the highest allowed request rate, cut short the minimum off-time after a primary conduction cycle, or arrive while the primary is still conducting. When the noise-reduction input is set, a request is also held back if it would land in the audible skip band measured from the last conduction cycle.

The driver reports each request it actually sends with `req_issued`. The end of each primary conduction cycle arrives as a one-cycle `fall_strobe`. Every time span is a parameter counted in clock cycles. Requests that are held back are not stored. The gated output simply follows the raw request whenever nothing inhibits it. A 3-bit code reports which rule is currently in force, chosen by a fixed priority.

The design has three parts. A two-state lockout machine has the states LK_OPEN and LK_ARMED. Its transitions are ISSUE (LK_OPEN to LK_ARMED on `req_issued`), EDGE (LK_ARMED to LK_OPEN on `fall_strobe`) and EXPIRE (LK_ARMED to LK_OPEN after `LOCK_CYC` cycles). A three-state skip tracker has the states SK_FREE, SK_WAIT and SK_BAND. Its transitions are RESTART (any state to SK_WAIT on `fall_strobe`), ENTER (SK_WAIT to SK_BAND when the cycle age reaches `SKIP_LO_CYC`) and LEAVE (SK_BAND to SK_FREE when the age reaches `SKIP_HI_CYC`). Two down-count hold timers cover the request rate and the off-time.

Top module: `srg_gate`

## Requirements
- R1: After a cycle in which `req_issued` is high, the code is 2 (rate) for the next `RATE_CYC`-1 cycles, unless a higher-priority rule is active. Passed requests are therefore at least `RATE_CYC` cycles apart.
- R2: After a cycle in which `fall_strobe` is high, the code is 3 (off-time) for the next `OFF_CYC` cycles, unless a higher-priority rule is active.
- R3: A request issued while the lockout is open puts the code at 1 (on-time lockout) from the next cycle. The lockout lasts up to and including the cycle in which `fall_strobe` is seen. A strobe that comes while the lockout is open has no effect on the lockout.
- R4: If no `fall_strobe` arrives, the lockout ends by itself after exactly `LOCK_CYC` cycles.
- R5: The age of a cycle is the number of cycles since the last `fall_strobe` (the cycle after the strobe has age 1). With `quiet_en` high, the code is 4 (skip) while the age is from `SKIP_LO_CYC` to `SKIP_HI_CYC`-1. With `quiet_en` low, the window blocks nothing. Each strobe restarts the window.
- R6: A blocked request is not stored. `req_gated` is high only in a cycle where `req_raw` is high, so after the window closes nothing passes unless the raw request is raised again.
- R7: `req_gated` equals `req_raw` when the code is 0 and is low otherwise. When several rules are active at once, the code shows the highest-priority one, in the order lockout (1), rate (2), off-time (3), skip (4).
- R8: During and after reset all timers are expired, the lockout is open and the skip window is closed. The code is 0 and the first raw request passes at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_raw | input | 1 | Raw cycle request from the regulation loop |
| req_issued | input | 1 | High in a cycle in which the driver sent a request |
| fall_strobe | input | 1 | One-cycle strobe marking the end of a primary conduction cycle |
| quiet_en | input | 1 | Enables the audible-band skip window |
| req_gated | output | 1 | Request allowed through this cycle |
| inhibit_code | output | 3 | Active inhibit: 0 none, 1 lockout, 2 rate, 3 off-time, 4 skip |

## Verification
The assertions check a set of rules on every cycle. Passed requests must keep the rate spacing, must stay clear of the off-time and, when enabled, of the skip band, and must never pass without a raw request. An issued request must be followed by the lockout code, and no lockout run may be longer than its timeout. Only the bench's scenarios can show the rest. These are the exact cycle in which each code starts and ends, the priority order when rules overlap, the effect of `quiet_en` being low, the fact that held-back requests are not stored, and the reset state.

// File: rtl/srg_pkg.sv
package srg_pkg;

    // Inhibit reason codes, value order equals priority (1 highest)
    typedef enum logic [2:0] {
        INH_NONE    = 3'd0,
        INH_ONTIME  = 3'd1,
        INH_RATE    = 3'd2,
        INH_OFFTIME = 3'd3,
        INH_SKIP    = 3'd4
    } inhibit_e;

    localparam int NUM_RULES = 4;

    typedef enum logic {
        LK_OPEN  = 1'b0,
        LK_ARMED = 1'b1
    } lock_state_e;

    typedef enum logic [1:0] {
        SK_FREE = 2'd0,
        SK_WAIT = 2'd1,
        SK_BAND = 2'd2
    } skip_state_e;

endpackage

// File: rtl/srg_hold_timer.sv
module srg_hold_timer #(
    parameter int CNT = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int CW = (CNT < 1) ? 1 : $clog2(CNT + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(CNT);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= LOAD_VAL;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    always_comb begin
        busy = (remain != '0);
    end
endmodule

// File: rtl/srg_lockout.sv
module srg_lockout
    import srg_pkg::*;
#(
    parameter int TIMEOUT = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic edge_seen,
    output logic active
);
    localparam int AW = $clog2(TIMEOUT + 1);
    localparam logic [AW-1:0] AGE_LAST = AW'(TIMEOUT - 1);

    lock_state_e   state;
    lock_state_e   state_nxt;
    logic [AW-1:0] age;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LK_OPEN;
        end else begin
            state <= state_nxt;
        end
    end

    // cycles spent armed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= '0;
        end else if (state == LK_OPEN) begin
            age <= '0;
        end else begin
            age <= age + 1'b1;
        end
    end

    // transitions: ISSUE, EDGE, EXPIRE
    always_comb begin
        state_nxt = state;
        unique case (state)
            LK_OPEN: begin
                if (issue) begin
                    state_nxt = LK_ARMED;
                end
            end
            LK_ARMED: begin
                if (edge_seen) begin
                    state_nxt = LK_OPEN;
                end else if (age == AGE_LAST) begin
                    state_nxt = LK_OPEN;
                end
            end
            default: state_nxt = LK_OPEN;
        endcase
    end

    // outputs
    always_comb begin
        active = (state == LK_ARMED);
    end
endmodule

// File: rtl/srg_skip_window.sv
module srg_skip_window
    import srg_pkg::*;
#(
    parameter int LO = 40,
    parameter int HI = 70
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_seen,
    output logic in_band
);
    localparam int AW = $clog2(HI + 1);
    localparam logic [AW-1:0] ENTER_AGE = AW'(LO - 1);
    localparam logic [AW-1:0] LEAVE_AGE = AW'(HI - 1);

    skip_state_e   state;
    skip_state_e   state_nxt;
    logic [AW-1:0] age;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SK_FREE;
        end else begin
            state <= state_nxt;
        end
    end

    // age of the current cycle since the last strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= '0;
        end else if (edge_seen) begin
            age <= AW'(1);
        end else if (state != SK_FREE) begin
            age <= age + 1'b1;
        end else begin
            age <= '0;
        end
    end

    // transitions: RESTART, ENTER, LEAVE
    always_comb begin
        state_nxt = state;
        if (edge_seen) begin
            state_nxt = SK_WAIT;
        end else begin
            unique case (state)
                SK_FREE: state_nxt = SK_FREE;
                SK_WAIT: begin
                    if (age == ENTER_AGE) begin
                        state_nxt = SK_BAND;
                    end
                end
                SK_BAND: begin
                    if (age == LEAVE_AGE) begin
                        state_nxt = SK_FREE;
                    end
                end
                default: state_nxt = SK_FREE;
            endcase
        end
    end

    // outputs
    always_comb begin
        in_band = (state == SK_BAND);
    end
endmodule

// File: rtl/srg_priority.sv
module srg_priority
    import srg_pkg::*;
#(
    parameter int N = NUM_RULES
) (
    input  logic [N-1:0] flags,
    output logic [2:0]   code
);
    logic [N:0]   taken;
    logic [N-1:0] win;

    assign taken[0] = 1'b0;

    for (genvar g = 0; g < N; g++) begin : g_rule
        assign win[g]       = flags[g] & ~taken[g];
        assign taken[g + 1] = taken[g] | flags[g];
    end

    always_comb begin
        code = 3'(INH_NONE);
        for (int i = 0; i < N; i++) begin
            if (win[i]) begin
                code = code | 3'(i + 1);
            end
        end
    end
endmodule

// File: rtl/srg_gate.sv
module srg_gate
    import srg_pkg::*;
#(
    parameter int RATE_CYC    = 10,
    parameter int OFF_CYC     = 6,
    parameter int LOCK_CYC    = 300,
    parameter int SKIP_LO_CYC = 40,
    parameter int SKIP_HI_CYC = 70
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_raw,
    input  logic       req_issued,
    input  logic       fall_strobe,
    input  logic       quiet_en,
    output logic       req_gated,
    output logic [2:0] inhibit_code
);
    logic                 lock_on;
    logic                 rate_busy;
    logic                 off_busy;
    logic                 band_on;
    logic [NUM_RULES-1:0] rules;
    logic [2:0]           code;

    srg_lockout #(.TIMEOUT(LOCK_CYC)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (req_issued),
        .edge_seen (fall_strobe),
        .active    (lock_on)
    );

    srg_hold_timer #(.CNT(RATE_CYC - 1)) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (req_issued),
        .busy  (rate_busy)
    );

    srg_hold_timer #(.CNT(OFF_CYC)) u_off (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (fall_strobe),
        .busy  (off_busy)
    );

    srg_skip_window #(.LO(SKIP_LO_CYC), .HI(SKIP_HI_CYC)) u_skip (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_seen (fall_strobe),
        .in_band   (band_on)
    );

    // index order equals priority order
    assign rules = {band_on & quiet_en, off_busy, rate_busy, lock_on};

    srg_priority #(.N(NUM_RULES)) u_prio (
        .flags (rules),
        .code  (code)
    );

    always_comb begin
        inhibit_code = code;
        req_gated    = req_raw & (code == 3'(INH_NONE));
    end
endmodule

// File: rtl/srg_gate_chk.sv
module srg_gate_chk #(
    parameter int RATE_CYC    = 10,
    parameter int OFF_CYC     = 6,
    parameter int LOCK_CYC    = 300,
    parameter int SKIP_LO_CYC = 40,
    parameter int SKIP_HI_CYC = 70
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_raw,
    input logic       req_issued,
    input logic       fall_strobe,
    input logic       quiet_en,
    input logic       req_gated,
    input logic [2:0] inhibit_code
);
    localparam int CAP = ((OFF_CYC > SKIP_HI_CYC) ? OFF_CYC : SKIP_HI_CYC) + 1;

    int since_iss;
    int since_stb;
    int lock_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_iss <= RATE_CYC;
            since_stb <= CAP;
            lock_run  <= 0;
        end else begin
            if (req_issued) begin
                since_iss <= 1;
            end else if (since_iss < RATE_CYC) begin
                since_iss <= since_iss + 1;
            end
            if (fall_strobe) begin
                since_stb <= 1;
            end else if (since_stb < CAP) begin
                since_stb <= since_stb + 1;
            end
            if (inhibit_code == 3'd1) begin
                lock_run <= lock_run + 1;
            end else begin
                lock_run <= 0;
            end
        end
    end

    // R1
    rate_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_gated |-> since_iss >= RATE_CYC)
        else $error("rate spacing broken");

    // R2
    off_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_gated |-> since_stb > OFF_CYC)
        else $error("off-time broken");

    // R3
    lock_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_gated && req_issued) |=> inhibit_code == 3'd1)
        else $error("lockout did not start");

    // R3
    lock_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit_code == 3'd1 && fall_strobe) |=> inhibit_code != 3'd1)
        else $error("lockout outlived strobe");

    // R4
    lock_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit_code == 3'd1) |-> lock_run < LOCK_CYC)
        else $error("lockout exceeded timeout");

    // R5
    skip_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_en && req_gated) |-> !(since_stb >= SKIP_LO_CYC && since_stb < SKIP_HI_CYC))
        else $error("request inside skip band");

    // R6
    no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_raw |-> !req_gated)
        else $error("request passed without raw request");

    // R7
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_code <= 3'd4)
        else $error("code out of range");

    // R7
    gate_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_gated |-> inhibit_code == 3'd0)
        else $error("request passed while inhibited");
endmodule

bind srg_gate srg_gate_chk #(
    .RATE_CYC    (RATE_CYC),
    .OFF_CYC     (OFF_CYC),
    .LOCK_CYC    (LOCK_CYC),
    .SKIP_LO_CYC (SKIP_LO_CYC),
    .SKIP_HI_CYC (SKIP_HI_CYC)
) u_chk (.*);

// File: tb/srg_gate_tb.sv
module srg_gate_tb;
    localparam int RATE = 10;
    localparam int OFF  = 6;
    localparam int LOCK = 300;
    localparam int LO   = 40;
    localparam int HI   = 70;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_raw = 1'b0;
    logic       req_issued = 1'b0;
    logic       fall_strobe = 1'b0;
    logic       quiet_en = 1'b0;
    logic       req_gated;
    logic [2:0] inhibit_code;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit last_iss = 1'b0;

    // reference model state (state of the coming cycle)
    bit m_lk = 1'b0;
    int m_lkage = 0;
    int m_rate = 0;
    int m_off = 0;
    int m_age = 0;

    always #5 clk = ~clk;

    srg_gate #(
        .RATE_CYC(RATE), .OFF_CYC(OFF), .LOCK_CYC(LOCK),
        .SKIP_LO_CYC(LO), .SKIP_HI_CYC(HI)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_raw(req_raw), .req_issued(req_issued),
        .fall_strobe(fall_strobe), .quiet_en(quiet_en),
        .req_gated(req_gated), .inhibit_code(inhibit_code)
    );

    function automatic int exp_code(bit q);
        if (m_lk) return 1;
        if (m_rate > 0) return 2;
        if (m_off > 0) return 3;
        if (q && m_age >= LO && m_age < HI) return 4;
        return 0;
    endfunction

    function automatic string tag_of(int c);
        case (c)
            1: return "R3/R4";
            2: return "R1";
            3: return "R2";
            4: return "R5";
            default: return "R7";
        endcase
    endfunction

    task automatic check(bit ok, string tag, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic model_update(bit iss, bit s);
        if (m_lk) begin
            if (s) m_lk = 1'b0;
            else if (m_lkage >= LOCK) m_lk = 1'b0;
            else m_lkage++;
        end else if (iss) begin
            m_lk = 1'b1;
            m_lkage = 1;
        end
        if (iss) m_rate = RATE - 1;
        else if (m_rate > 0) m_rate--;
        if (s) m_off = OFF;
        else if (m_off > 0) m_off--;
        if (s) m_age = 1;
        else if (m_age > 0 && m_age < 100000) m_age++;
    endtask

    // one cycle: drive, issue what passes, compare, update model
    task automatic step(bit raw, bit s, bit q);
        int ec;
        bit eg;
        @(negedge clk);
        req_raw = raw;
        fall_strobe = s;
        quiet_en = q;
        #1;
        req_issued = req_gated;
        #1;
        ec = exp_code(q);
        eg = raw && (ec == 0);
        check(int'(inhibit_code) == ec, tag_of(ec), int'(inhibit_code), ec);
        check(req_gated == eg, (!raw) ? "R6" : tag_of(ec), int'(req_gated), int'(eg));
        last_iss = req_issued;
        @(posedge clk);
        model_update(req_issued, s);
    endtask

    // raise the request until one passes, then strobe after dly cycles
    task automatic issue_then_strobe(int dly, bit q);
        int guard = 0;
        last_iss = 1'b0;
        while (!last_iss && guard < 1000) begin
            step(1'b1, 1'b0, q);
            guard++;
        end
        for (int i = 1; i < dly; i++) step(1'b0, 1'b0, q);
        step(1'b0, 1'b1, q);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        int run;
        void'($urandom(32'd20240611));

        // R8: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        req_raw = 1'b1;
        #2;
        check(inhibit_code == 3'd0, "R8", int'(inhibit_code), 0);
        req_raw = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R8: first request passes at once
        step(1'b1, 1'b0, 1'b0);
        check(last_iss == 1'b1, "R8", int'(last_iss), 1);

        // R4: lockout runs exactly LOCK cycles without a strobe
        run = 0;
        for (int i = 0; i < LOCK + 5; i++) begin
            step(1'b0, 1'b0, 1'b0);
            if (inhibit_code == 3'd1) run++;
        end
        check(run == LOCK, "R4", run, LOCK);

        // R3/R1/R2/R7: strobe during lockout, overlapping rate and off-time
        issue_then_strobe(4, 1'b1);
        check(inhibit_code == 3'd1, "R3", int'(inhibit_code), 1);
        step(1'b0, 1'b0, 1'b1);
        check(inhibit_code == 3'd2, "R7", int'(inhibit_code), 2);

        // R5: requests inside band are blocked with quiet_en set
        while (m_age != LO) step(1'b0, 1'b0, 1'b1);
        for (int a = LO; a < HI; a++) begin
            step(1'b1, 1'b0, 1'b1);
            check(inhibit_code == 3'd4 && !req_gated, "R5", int'(inhibit_code), 4);
        end
        step(1'b1, 1'b0, 1'b1);
        check(last_iss == 1'b1, "R5", int'(last_iss), 1);

        // R6: one blocked pulse inside band is not remembered
        for (int i = 0; i < 2; i++) step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        while (m_age != LO + 5) step(1'b0, 1'b0, 1'b1);
        step(1'b1, 1'b0, 1'b1);
        check(!req_gated, "R6", int'(req_gated), 0);
        run = 0;
        for (int i = 0; i < HI; i++) begin
            step(1'b0, 1'b0, 1'b1);
            if (req_gated) run++;
        end
        check(run == 0, "R6", run, 0);

        // R5: quiet_en low lets a request through inside the band
        issue_then_strobe(3, 1'b0);
        while (m_age != LO + 5) step(1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        check(last_iss == 1'b1 && inhibit_code == 3'd0, "R5", int'(inhibit_code), 0);

        // R3: strobe while lockout open leaves lockout untouched
        for (int i = 0; i < RATE + OFF; i++) step(1'b0, (i == 2), 1'b0);
        while (m_lk || m_rate > 0 || m_off > 0) step(1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        check(inhibit_code == 3'd1, "R3", int'(inhibit_code), 1);

        // random phase
        for (int i = 0; i < 8000; i++) begin
            bit r;
            bit s;
            bit q;
            r = ($urandom_range(0, 9) < 7);
            if (m_lk) s = ($urandom_range(0, 7) == 0);
            else s = ($urandom_range(0, 49) == 0);
            q = ((i / 500) % 2) == 1;
            step(r, s, q);
        end

        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            report();
            $finish;
        end
    end
endmodule